// File: doc/BRIEF.md
# Driver Impedance Calibration Sequencer

This block finds the output-driver and termination impedance codes of a memory interface pad. It compares each calibration leg against an external precision resistor. For each leg it presents a drive code to the analog calibration circuit. It waits for the circuit to settle, then samples the single-bit comparator. It stops at the lowest code where the comparator shows the polarity that counts as a pass for that leg.

A one-cycle `start` pulse launches a pass over three legs in a fixed order: pull-up drive, then pull-down drive, then pull-down termination. The pull-up result stays on the P-side code lines while the two pull-down legs sweep the N-side code. The pull-up termination leg is never swept, and its result is always zero.

When the third leg finishes, the block raises `done` for one cycle. It then holds all results and the per-leg failure flags until the next start. The reference-voltage select presented to the comparator follows the active leg and the termination mode. That mode is captured when `start` is accepted.

Top module: `imp_cal_seq`

## Requirements
- R1: In the pull-up drive leg, `en_p`=1 and `en_n`=0. The P code starts at 0 and rises by one each time a settle interval of SETTLE_CYC clock cycles ends with no pass.
- R2: The pull-up leg passes at the first code where the synchronised comparator reads 1. That code is stored as `res_pu_drv`. It stays on `drv_p_code` while the later legs run and after they finish.
- R3: In the pull-down drive leg, both enables are 0. The N code sweeps upward from 0, and the leg passes at the first code where the comparator reads 0.
- R4: In the pull-down termination leg, `en_p`=0 and `en_n`=1. The N code sweeps upward from 0, and the leg passes at the first code where the comparator reads 0.
- R5: If a leg reaches the top code without passing, its result is the top code (31 at default width). Its failure bit is then set: bit 0 for pull-up drive, bit 1 for pull-down drive, bit 2 for pull-down termination.
- R6: `res_pu_odt` is always 0.
- R7: `vref_sel` is 0x37 for the pull-up drive and pull-down termination legs when termination is off, and 0x3A when it is on. It is 0x33 for the pull-down drive leg in either mode, and 0 when idle. The termination mode is the `term_on` value seen on the cycle `start` is accepted.
- R8: `done` is high for exactly one cycle, starting the cycle after the final sample of the last leg. Results and failure bits stay stable until the next accepted `start`, which clears them to 0.
- R9: A `start` pulse while a calibration is running has no effect on the sweep, the codes or the results.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a calibration pass (ignored while busy) |
| term_on | input | 1 | Termination mode, selects reference voltage set |
| cmp_in | input | 1 | Asynchronous comparator output from the analog leg |
| drv_p_code | output | CODE_W | Pull-up code driven to the calibration leg |
| drv_n_code | output | CODE_W | Pull-down code driven to the calibration leg |
| en_p | output | 1 | P-side calibration enable |
| en_n | output | 1 | N-side calibration enable |
| vref_sel | output | 8 | Comparator reference-voltage select |
| res_pu_drv | output | CODE_W | Pull-up drive result |
| res_pd_drv | output | CODE_W | Pull-down drive result |
| res_pu_odt | output | CODE_W | Pull-up termination result (always 0) |
| res_pd_odt | output | CODE_W | Pull-down termination result |
| fail | output | 3 | Per-leg failure flags |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with SETTLE_CYC=4, keeping the default 5-bit code and two synchroniser stages. A full three-leg sweep to the top code then costs under 400 cycles. The short interval still exceeds the synchroniser depth, so every sample reflects the code presented during that interval. This makes exhaustive-length sweeps affordable. They include legs that pass at code 0, legs that pass at exactly code 31, and legs that never pass. Each leg runs under both termination modes, with `term_on` toggled after start to show that it was captured.

// File: rtl/imp_cal_pkg.sv
package imp_cal_pkg;

    localparam int VREF_W   = 8;
    localparam int NUM_LEGS = 3;

    typedef enum logic [1:0] {
        LEG_PU_DRV = 2'd0,
        LEG_PD_DRV = 2'd1,
        LEG_PD_ODT = 2'd2
    } leg_e;

    // Reference-voltage select for a leg under a termination mode.
    function automatic logic [VREF_W-1:0] vref_code(leg_e leg, logic term_on);
        case (leg)
            LEG_PU_DRV: return term_on ? 8'h3A : 8'h37;
            LEG_PD_DRV: return 8'h33;
            LEG_PD_ODT: return term_on ? 8'h3A : 8'h37;
            default:    return '0;
        endcase
    endfunction

    // Comparator level that counts as a pass on a leg.
    function automatic logic pass_level(leg_e leg);
        return (leg == LEG_PU_DRV);
    endfunction

    function automatic leg_e next_leg(leg_e leg);
        case (leg)
            LEG_PU_DRV: return LEG_PD_DRV;
            default:    return LEG_PD_ODT;
        endcase
    endfunction

endpackage

// File: rtl/imp_cal_sync.sv
module imp_cal_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    // STAGES must be 2 or more.
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/imp_cal_timer.sv
module imp_cal_timer #(
    parameter int SETTLE_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic tick
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active)       cnt <= '0;
        else if (cnt == CNT_LAST) cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end

    assign tick = active && (cnt == CNT_LAST);

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick || (SETTLE_CYC == 1)) else $error("tick spacing"); // R1
endmodule

// File: rtl/imp_cal_ctrl.sv
module imp_cal_ctrl
    import imp_cal_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             start,
    input  logic                             term_on,
    input  logic                             tick,
    input  logic                             cmp_s,
    output logic                             running,
    output leg_e                             leg,
    output logic [CODE_W-1:0]                code,
    output logic                             term_q,
    output logic [NUM_LEGS-1:0][CODE_W-1:0]  res_q,
    output logic [NUM_LEGS-1:0]              fail_q,
    output logic                             done
);
    localparam logic [CODE_W-1:0] CODE_LAST = '1;

    logic sample_pass;
    logic leg_over;

    always_comb begin
        sample_pass = (cmp_s == pass_level(leg));
        leg_over    = sample_pass || (code == CODE_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            leg     <= LEG_PU_DRV;
            code    <= '0;
            term_q  <= 1'b0;
            res_q   <= '0;
            fail_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!running) begin
                if (start) begin
                    running <= 1'b1;
                    leg     <= LEG_PU_DRV;
                    code    <= '0;
                    term_q  <= term_on;
                    res_q   <= '0;
                    fail_q  <= '0;
                end
            end else if (tick) begin
                if (leg_over) begin
                    res_q[leg] <= code;
                    if (!sample_pass) fail_q[leg] <= 1'b1;
                    code <= '0;
                    if (leg == LEG_PD_ODT) begin
                        running <= 1'b0;
                        done    <= 1'b1;
                    end else begin
                        leg <= next_leg(leg);
                    end
                end else begin
                    code <= code + 1'b1;
                end
            end
        end
    end

    AST_CODE_STEP: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running) && leg == $past(leg) && code != $past(code))
        |-> code == CODE_W'($past(code) + 1'b1)) else $error("code step"); // R1

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done width"); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!running && !start) |=> ($stable(res_q) && $stable(fail_q))) else $error("idle hold"); // R8

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (running && !tick) |=> ($stable(leg) && $stable(code) && $stable(term_q))) else $error("busy start"); // R9

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_fail_chk
        AST_FAIL_CLAMP: assert property (@(posedge clk) disable iff (rst)
            $rose(fail_q[g]) |-> res_q[g] == CODE_LAST) else $error("fail clamp"); // R5
    end
endmodule

// File: rtl/imp_cal_seq.sv
module imp_cal_seq
    import imp_cal_pkg::*;
#(
    parameter int CODE_W      = 5,
    parameter int SETTLE_CYC  = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              term_on,
    input  logic              cmp_in,
    output logic [CODE_W-1:0] drv_p_code,
    output logic [CODE_W-1:0] drv_n_code,
    output logic              en_p,
    output logic              en_n,
    output logic [7:0]        vref_sel,
    output logic [CODE_W-1:0] res_pu_drv,
    output logic [CODE_W-1:0] res_pd_drv,
    output logic [CODE_W-1:0] res_pu_odt,
    output logic [CODE_W-1:0] res_pd_odt,
    output logic [2:0]        fail,
    output logic              done
);
    logic                            cmp_s;
    logic                            tick;
    logic                            running;
    leg_e                            leg;
    logic [CODE_W-1:0]               code;
    logic                            term_q;
    logic [NUM_LEGS-1:0][CODE_W-1:0] res_q;
    logic [NUM_LEGS-1:0]             fail_q;

    imp_cal_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst (rst), .d (cmp_in), .q (cmp_s)
    );

    imp_cal_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk (clk), .rst (rst), .active (running), .tick (tick)
    );

    imp_cal_ctrl #(.CODE_W(CODE_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .term_on (term_on),
        .tick    (tick),
        .cmp_s   (cmp_s),
        .running (running),
        .leg     (leg),
        .code    (code),
        .term_q  (term_q),
        .res_q   (res_q),
        .fail_q  (fail_q),
        .done    (done)
    );

    always_comb begin
        en_p       = running && (leg == LEG_PU_DRV);
        en_n       = running && (leg == LEG_PD_ODT);
        drv_p_code = en_p ? code : res_q[LEG_PU_DRV];
        drv_n_code = (running && leg != LEG_PU_DRV) ? code : '0;
        vref_sel   = running ? vref_code(leg, term_q) : '0;
        res_pu_drv = res_q[LEG_PU_DRV];
        res_pd_drv = res_q[LEG_PD_DRV];
        res_pd_odt = res_q[LEG_PD_ODT];
        res_pu_odt = '0;
        fail       = fail_q;
    end

    AST_ENABLE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(en_p && en_n)) else $error("both enables"); // R4

    AST_PU_HELD: assert property (@(posedge clk) disable iff (rst)
        (running && !en_p) |-> drv_p_code == res_pu_drv) else $error("pu code held"); // R2
endmodule

// File: tb/imp_cal_seq_bench.sv
module imp_cal_seq_bench;
    localparam int CW = 5;
    localparam int S  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic term_on = 1'b0;
    logic cmp_in;
    logic [CW-1:0] drv_p_code, drv_n_code, res_pu_drv, res_pd_drv, res_pu_odt, res_pd_odt;
    logic en_p, en_n, done;
    logic [7:0] vref_sel;
    logic [2:0] fail;

    int thr [3] = '{0, 0, 0};
    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    imp_cal_seq #(.CODE_W(CW), .SETTLE_CYC(S), .SYNC_STAGES(2)) u_imp_cal_seq (
        .clk(clk), .rst(rst), .start(start), .term_on(term_on), .cmp_in(cmp_in),
        .drv_p_code(drv_p_code), .drv_n_code(drv_n_code), .en_p(en_p), .en_n(en_n),
        .vref_sel(vref_sel), .res_pu_drv(res_pu_drv), .res_pd_drv(res_pd_drv),
        .res_pu_odt(res_pu_odt), .res_pd_odt(res_pd_odt), .fail(fail), .done(done)
    );

    // Analog leg model: pull-up trips high at its threshold, pull-downs trip low.
    always_comb begin
        if (en_p)      cmp_in = (int'(drv_p_code) >= thr[0]);
        else if (en_n) cmp_in = (int'(drv_n_code) <  thr[2]);
        else           cmp_in = (int'(drv_n_code) <  thr[1]);
    end

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_cal(input int a, input int b, input int c, input bit term, input int mid_t);
        int r [3];
        int f [3];
        int cnt [3];
        int total;
        thr[0] = a; thr[1] = b; thr[2] = c;
        total = 0;
        for (int i = 0; i < 3; i++) begin
            r[i]   = (thr[i] <= 31) ? thr[i] : 31;
            f[i]   = (thr[i] > 31) ? 1 : 0;
            cnt[i] = r[i] + 1;
            total += cnt[i];
        end
        start = 1'b1; term_on = term;
        @(negedge clk);
        start = 1'b0; term_on = ~term;
        for (int t = 0; t <= total * S + 4; t++) begin
            int n, L, k, ev;
            n = t / S;
            if (n < cnt[0])                       begin L = 0; k = n; end
            else if (n < cnt[0] + cnt[1])         begin L = 1; k = n - cnt[0]; end
            else if (n < total)                   begin L = 2; k = n - cnt[0] - cnt[1]; end
            else                                  begin L = 3; k = 0; end
            ev = (L == 1) ? 8'h33 : (L == 3) ? 0 : (term ? 8'h3A : 8'h37);
            if (L == 0) begin
                check("R1 en_p", int'(en_p), 1);
                check("R1 en_n", int'(en_n), 0);
                check("R1 p code sweep", int'(drv_p_code), k);
            end else if (L == 1) begin
                check("R3 enables", int'({en_p, en_n}), 0);
                check("R3 n code sweep", int'(drv_n_code), k);
                check("R2 p code held", int'(drv_p_code), r[0]);
            end else if (L == 2) begin
                check("R4 enables", int'({en_p, en_n}), 1);
                check("R4 n code sweep", int'(drv_n_code), k);
                check("R2 p code held", int'(drv_p_code), r[0]);
            end else begin
                check("R8 idle enables", int'({en_p, en_n}), 0);
                check("R2 p code after run", int'(drv_p_code), r[0]);
            end
            check("R7 vref", int'(vref_sel), ev);
            check("R2 pu result", int'(res_pu_drv), (L >= 1) ? r[0] : 0);
            check("R3 pd result", int'(res_pd_drv), (L >= 2) ? r[1] : 0);
            check("R4 odt result", int'(res_pd_odt), (L >= 3) ? r[2] : 0);
            check("R6 pu odt zero", int'(res_pu_odt), 0);
            check("R5 fail bits", int'(fail),
                  ((L >= 3 && f[2] == 1) ? 4 : 0) + ((L >= 2 && f[1] == 1) ? 2 : 0) +
                  ((L >= 1 && f[0] == 1) ? 1 : 0));
            check("R8 done", int'(done), (t == total * S) ? 1 : 0);
            start = (t == mid_t); // R9: pulse mid-run must change nothing
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset codes", int'({drv_p_code, drv_n_code}), 0);
        check("R10 reset enables", int'({en_p, en_n, done}), 0);
        check("R10 reset vref", int'(vref_sel), 0);
        check("R10 reset results", int'({res_pu_drv, res_pd_drv, res_pd_odt, fail}), 0);
        rst = 1'b0;
        @(negedge clk);
        run_cal(5, 7, 9, 1'b0, 10);
        run_cal(0, 0, 0, 1'b1, 2);
        run_cal(31, 40, 12, 1'b1, 60);
        run_cal(40, 3, 40, 1'b0, 150);
        run_cal(17, 31, 1, 1'b0, -1);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule